// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block generates the active-low reset for a host processor. It holds that reset at power-up, whenever a synchronous low-supply flag is raised, and for a fixed pulse after the watchdog runs out. All time intervals are counted in pulses of a millisecond tick input. The interval lengths are parameters given in tick counts, so a testbench can shorten them.

The watchdog needs no dedicated kick pin. It is restarted by a start condition on the shared two-wire serial bus, meaning SDA falls while SCL is high. Both bus lines pass through two-flop synchronizers before the start condition is detected. A two-bit select input sets one of three timeout lengths or turns the watchdog off.

While the host reset is active, the block raises a hold signal. The serial interface uses it to abort any transaction in progress and to refuse new ones. A second, independent supply monitor output copies its own low flag with no delay.

Top module: `supv_reset_wdt`

## Requirements
- R1: After `rst_n` is released, `host_rst_n` stays low until `POR_TICKS` tick pulses have been seen with `vlow` low. It goes high on the clock edge that samples the last of those ticks.
- R2: When `vlow` is sampled high in any state, `host_rst_n` is low after that edge. Release then needs a fresh, uninterrupted run of `POR_TICKS` ticks with `vlow` low.
- R3: A start condition restarts the watchdog count. A start condition is a falling SDA while SCL is high, both seen after the two-flop synchronizers. Kicking more often than the selected period keeps `host_rst_n` high.
- R4: A falling SDA while SCL is low is not a start condition and does not restart the watchdog.
- R5: `wdsel` selects the timeout: 2'b00 gives `WD_LONG` ticks, 2'b01 gives `WD_MID` ticks, 2'b10 gives `WD_SHORT` ticks, and 2'b11 turns the watchdog off so it never expires.
- R6: When the watchdog expires, `host_rst_n` goes low for `PULSE_TICKS` ticks and then goes high again.
- R7: `bus_hold` is high exactly when `host_rst_n` is low.
- R8: `v2_fail_n` is the combinational inverse of `v2low`. Neither the main reset nor `rst_n` affects it.
- R9: The watchdog count is held at zero while reset is active. After any release, a full timeout period passes before the next expiry.
- R10: A raised `vlow` during a watchdog reset pulse replaces the rest of the pulse with a full `POR_TICKS` interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| tick_ms | input | 1 | One-cycle time-base pulse, nominally 1 ms |
| vlow | input | 1 | Synchronous main low-supply flag, active high |
| v2low | input | 1 | Second monitor low flag, active high |
| wdsel | input | 2 | Watchdog timeout select |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| host_rst_n | output | 1 | Active-low reset to the host |
| bus_hold | output | 1 | Abort and block serial transactions |
| v2_fail_n | output | 1 | Active-low second monitor fail |

## Verification
A change on `vlow` shows on `host_rst_n` and `bus_hold` one clock edge later. A bus edge needs three edges (two synchronizer stages and one history flop) before it can clear the watchdog count. Each release and each expiry happens on the edge that samples the deciding tick. `v2_fail_n` follows in the same cycle.

A behavioural model in the bench applies these latencies at every rising edge. It is compared with the outputs one time step after each falling edge, so the inputs driven on that falling edge have settled. The scenario checks measure intervals in cycles and allow a window of one tick period around the expected tick count.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2
  } rst_state_e;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supv_start_det.sv
module supv_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  // SDA high->low while SCL stays high across both samples
  assign start_o = sda_q & ~sda_s & scl_q & scl_s;
endmodule

// File: rtl/supv_wdt.sv
module supv_wdt
  import supv_pkg::*;
#(
  parameter int WD_LONG_T  = 1400,
  parameter int WD_MID_T   = 600,
  parameter int WD_SHORT_T = 200,
  parameter int CW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [1:0]    sel_i,
  input  logic          tick_i,
  input  logic          kick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;
  logic          enabled;
  logic          cnt_en;

  always_comb begin
    last_val = '0;
    enabled  = 1'b1;
    unique case (wd_sel_e'(sel_i))
      WD_LONG:  last_val = CW'(WD_LONG_T - 1);
      WD_MID:   last_val = CW'(WD_MID_T - 1);
      WD_SHORT: last_val = CW'(WD_SHORT_T - 1);
      default:  enabled  = 1'b0;
    endcase
  end

  assign expire_o = run_i & enabled & tick_i & ~kick_i & (cnt_q >= last_val);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i || !enabled || kick_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      cnt_d  = expire_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq
  import supv_pkg::*;
#(
  parameter int POR_TICKS   = 200,
  parameter int PULSE_TICKS = 250,
  parameter int CW          = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic vlow_i,
  input  logic expire_i,
  output logic run_o
);
  rst_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (vlow_i) begin
      st_d   = ST_POR;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_POR: if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == CW'(POR_TICKS - 1)) begin
            st_d  = ST_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PULSE: if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == CW'(PULSE_TICKS - 1)) begin
            st_d  = ST_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUN: if (expire_i) begin
          st_d   = ST_PULSE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        default: begin
          st_d   = ST_POR;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_POR;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/supv_reset_wdt.sv
module supv_reset_wdt
  import supv_pkg::*;
#(
  parameter int POR_TICKS   = 200,
  parameter int PULSE_TICKS = 250,
  parameter int WD_LONG_T   = 1400,
  parameter int WD_MID_T    = 600,
  parameter int WD_SHORT_T  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       vlow,
  input  logic       v2low,
  input  logic [1:0] wdsel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       host_rst_n,
  output logic       bus_hold,
  output logic       v2_fail_n
);
  localparam int WD_MAX = max2(WD_LONG_T, max2(WD_MID_T, WD_SHORT_T));
  localparam int WD_CW  = $clog2(WD_MAX + 1);
  localparam int SEQ_CW = $clog2(max2(POR_TICKS, PULSE_TICKS) + 1);

  logic [1:0] bus_s;
  logic       start_p;
  logic       run;
  logic       wd_expire;

  supv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  supv_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_s   (bus_s[0]),
    .scl_s   (bus_s[1]),
    .start_o (start_p)
  );

  supv_wdt #(
    .WD_LONG_T (WD_LONG_T),
    .WD_MID_T  (WD_MID_T),
    .WD_SHORT_T(WD_SHORT_T),
    .CW        (WD_CW)
  ) u_wdt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .sel_i    (wdsel),
    .tick_i   (tick_ms),
    .kick_i   (start_p),
    .expire_o (wd_expire)
  );

  supv_rst_seq #(
    .POR_TICKS  (POR_TICKS),
    .PULSE_TICKS(PULSE_TICKS),
    .CW         (SEQ_CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_ms),
    .vlow_i   (vlow),
    .expire_i (wd_expire),
    .run_o    (run)
  );

  assign host_rst_n = run;
  assign bus_hold   = ~run;
  assign v2_fail_n  = ~v2low;
endmodule

// File: rtl/supv_reset_wdt_chk.sv
module supv_reset_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_ms,
  input logic       vlow,
  input logic       v2low,
  input logic [1:0] wdsel,
  input logic       host_rst_n,
  input logic       bus_hold,
  input logic       v2_fail_n,
  input logic       wd_expire
);
  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_n) |-> $past(tick_ms));

  a_r2_low_supply_resets: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !host_rst_n);

  a_r5_off_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (wdsel == 2'b11) |-> !wd_expire);

  a_r6_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !host_rst_n);

  a_r7_hold_tracks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold == !host_rst_n);

  a_r8_second_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    v2_fail_n == !v2low);

  a_r9_no_expiry_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rst_n |-> !wd_expire);
endmodule

bind supv_reset_wdt supv_reset_wdt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_ms   (tick_ms),
  .vlow      (vlow),
  .v2low     (v2low),
  .wdsel     (wdsel),
  .host_rst_n(host_rst_n),
  .bus_hold  (bus_hold),
  .v2_fail_n (v2_fail_n),
  .wd_expire (wd_expire)
);

// File: tb/tb_supv_reset_wdt.sv
`timescale 1ns/1ps
module tb_supv_reset_wdt;
  localparam int POR_T = 8;
  localparam int PUL_T = 5;
  localparam int WL_T  = 40;
  localparam int WM_T  = 20;
  localparam int WS_T  = 10;
  localparam int TP    = 4;  // cycles per tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic vlow = 1'b0;
  logic v2low = 1'b0;
  logic [1:0] wdsel = 2'b11;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic host_rst_n, bus_hold, v2_fail_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int tdiv = 0;

  always #2.5 clk = ~clk;

  supv_reset_wdt #(
    .POR_TICKS(POR_T), .PULSE_TICKS(PUL_T),
    .WD_LONG_T(WL_T), .WD_MID_T(WM_T), .WD_SHORT_T(WS_T), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vlow(vlow), .v2low(v2low),
    .wdsel(wdsel), .scl_i(scl_i), .sda_i(sda_i),
    .host_rst_n(host_rst_n), .bus_hold(bus_hold), .v2_fail_n(v2_fail_n)
  );

  always @(negedge clk) begin
    tdiv    <= (tdiv == TP-1) ? 0 : tdiv + 1;
    tick_ms <= (tdiv == TP-1);
  end

  // behavioural reference model
  int  m_mode;  // 0 power-on wait, 1 pulse, 2 running
  int  m_cnt, m_wd;
  bit  sda_h[3];
  bit  scl_h[3];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_wd = 0;
      for (int i = 0; i < 3; i++) begin sda_h[i] = 1; scl_h[i] = 1; end
    end else begin
      bit st, exp_now;
      int lim;
      st  = sda_h[2] && !sda_h[1] && scl_h[1] && scl_h[2];
      lim = (wdsel == 2'b00) ? WL_T : (wdsel == 2'b01) ? WM_T :
            (wdsel == 2'b10) ? WS_T : 0;
      exp_now = (m_mode == 2) && (lim != 0) && tick_ms && !st && (m_wd >= lim-1);
      if (m_mode != 2 || lim == 0 || st) m_wd = 0;
      else if (tick_ms) m_wd = exp_now ? 0 : m_wd + 1;
      if (vlow) begin
        m_mode = 0; m_cnt = 0;
      end else if (m_mode == 0 || m_mode == 1) begin
        if (tick_ms) begin
          if (m_cnt == ((m_mode == 0) ? POR_T : PUL_T) - 1) begin
            m_mode = 2; m_cnt = 0;
          end else m_cnt++;
        end
      end else if (exp_now) begin
        m_mode = 1; m_cnt = 0;
      end
      sda_h[2] = sda_h[1]; sda_h[1] = sda_h[0]; sda_h[0] = sda_i;
      scl_h[2] = scl_h[1]; scl_h[1] = scl_h[0]; scl_h[0] = scl_i;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    check(host_rst_n == (m_mode == 2), cur_req, host_rst_n, m_mode == 2);
    check(bus_hold == (m_mode != 2), "R7", bus_hold, m_mode != 2);
    check(v2_fail_n == !v2low, "R8", v2_fail_n, !v2low);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_i = 1; sda_i = 1; cyc(3);
    sda_i = 0; cyc(3);
    scl_i = 0; cyc(2);
    sda_i = 1; cyc(2);
    scl_i = 1; cyc(1);
  endtask

  task automatic time_to(input bit lvl, input int maxc, output int n);
    n = 0;
    while (host_rst_n !== lvl && n < maxc) begin cyc(1); n++; end
  endtask

  int n;
  initial begin
    cyc(3);
    #1;
    check(host_rst_n == 0, "R1", host_rst_n, 0);
    check(bus_hold == 1, "R7", bus_hold, 1);
    @(negedge clk); rst_n = 1;
    cur_req = "R1";
    cyc(5 * TP); #1;
    check(host_rst_n == 0, "R1", host_rst_n, 0);
    time_to(1, 100, n);
    check(n >= (POR_T-5)*TP - TP && n <= (POR_T-5)*TP + TP, "R1", n, (POR_T-5)*TP);

    cur_req = "R8";
    @(negedge clk); v2low = 1; #1;
    check(v2_fail_n == 0, "R8", v2_fail_n, 0);
    check(host_rst_n == 1, "R8", host_rst_n, 1);
    @(negedge clk); v2low = 0; #1;
    check(v2_fail_n == 1, "R8", v2_fail_n, 1);

    cur_req = "R5";
    cyc(400); #1;
    check(host_rst_n == 1, "R5", host_rst_n, 1);

    cur_req = "R3";
    @(negedge clk); wdsel = 2'b10;
    for (int k = 0; k < 10; k++) begin bus_start(); cyc(12); end
    #1;
    check(host_rst_n == 1, "R3", host_rst_n, 1);

    cur_req = "R6";
    bus_start();
    time_to(0, 200, n);
    check(n >= (WS_T-1)*TP - 4 && n <= WS_T*TP + 4, "R5", n, WS_T*TP);
    time_to(1, 200, n);
    check(n >= (PUL_T-1)*TP && n <= PUL_T*TP + 1, "R6", n, PUL_T*TP);

    cur_req = "R9";
    time_to(0, 200, n);
    check(n >= (WS_T-1)*TP && n <= WS_T*TP + 1, "R9", n, WS_T*TP);
    time_to(1, 200, n);

    cur_req = "R4";
    for (int k = 0; k < 8; k++) begin
      scl_i = 0; cyc(2); sda_i = 0; cyc(2); sda_i = 1; cyc(2);
    end
    scl_i = 1;
    #1;
    check(host_rst_n == 0, "R4", host_rst_n, 0);
    time_to(1, 200, n);

    cur_req = "R5";
    @(negedge clk); wdsel = 2'b01;
    bus_start();
    time_to(0, 400, n);
    check(n >= (WM_T-1)*TP - 4 && n <= WM_T*TP + 4, "R5", n, WM_T*TP);
    time_to(1, 200, n);
    @(negedge clk); wdsel = 2'b00;
    bus_start();
    time_to(0, 400, n);
    check(n >= (WL_T-1)*TP - 4 && n <= WL_T*TP + 4, "R5", n, WL_T*TP);
    time_to(1, 200, n);

    cur_req = "R2";
    @(negedge clk); wdsel = 2'b11; cyc(10);
    vlow = 1; cyc(1); #1;
    check(host_rst_n == 0, "R2", host_rst_n, 0);
    vlow = 0;
    time_to(1, 200, n);
    check(n >= (POR_T-1)*TP && n <= POR_T*TP + 1, "R2", n, POR_T*TP);

    cur_req = "R10";
    @(negedge clk); wdsel = 2'b10;
    bus_start();
    time_to(0, 200, n);
    cyc(2 * TP);
    vlow = 1; cyc(1); vlow = 0;
    time_to(1, 200, n);
    check(n >= (POR_T-1)*TP && n <= POR_T*TP + 1, "R10", n, POR_T*TP);

    cyc(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule